// File: doc/BRIEF.md
# Bridge Target Retry and Disconnect Control

This block is the target-side control of a host bridge that sits on a 66 MHz PCI-style bus driven by FRAME#. It sees one address phase at a time, already split by the surrounding logic into a 4-bit bus command, the address and byte enables, and two range-hit flags: one for main memory and one for the secondary bus. From these it decides whether to claim the access and where to send it. Reads may only go to main memory. Writes may go to main memory or across to the secondary bus. Configuration cycles are never claimed.

Once an access is claimed, the block runs its data phases against a ready handshake from the memory side. It retries the first data phase in three cases: main memory is locked, a read must wait for processor posted or deferred writes to drain, or a pipelined or sideband request is pending after 32 wait clocks. Otherwise it holds wait states. After the first transfer, it disconnects any later data phase that stays unready for 8 clocks. A retried read is stored as a delayed transaction. Only a repeat of the same read (same command, address and byte enables) completes from that slot, and other reads are turned away while the slot is full.

Every output is a register. A pulse appears in the clock after the edge that samples its cause. `claim_o` rises in the clock after the address-phase edge and falls in the same clock as the terminating pulse (`retry_o`, `disconnect_o`, or the final `xfer_o`).

Top module: `brg_target_ctrl`

## Requirements
- R1: Only command codes 0110, 1110 and 1100 (reads) and 0111 and 1111 (writes) can be claimed. Configuration codes 1010 and 1011 are never claimed, and a read whose address does not hit main memory is not claimed.
- R2: A write that hits main memory is claimed with `to_mem_o`. A write that hits only the secondary bus is claimed with `to_sec_o`. When both ranges hit, main memory wins.
- R3: If `mem_locked_i` is high at a first-data-phase edge, `retry_o` pulses for any claimed access and `claim_o` drops.
- R4: If `posted_wr_pend_i` is high at a first-data-phase edge of a read, the read is retried. A write under the same condition is served normally.
- R5: With no retry cause, the first phase holds in wait states for as long as needed. The 32-clock retry fires only if `pipe_req_pend_i` is high, at the 32nd waiting first-phase edge or at any later waiting edge.
- R6: After a completed transfer, 8 consecutive unready edges in a later phase raise `disconnect_o` and end the access. Any transfer restarts that count, and 7 unready edges never disconnect.
- R7: A retried read pulses `dt_capture_o` together with `retry_o` and stores its command, address and byte enables, provided the delayed slot is empty.
- R8: While the slot is full, a read that differs in any stored field is retried without capture. An identical read is served with `dt_hit_o` alongside `xfer_o`, and this frees the slot.
- R9: A new address phase is accepted in the clock right after any termination (fast back-to-back), and the first-phase wait count starts again from zero.
- R10: If data becomes ready on the same edge at which the 32-clock retry would fire, the transfer wins and no retry is issued.
- R11: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_start_i | input | 1 | Address phase of a new access this clock |
| cmd_i | input | 4 | Bus command of the address phase |
| addr_i | input | ADDR_W | Access address |
| byte_en_i | input | BE_W | Byte enables of the access |
| hit_mem_i | input | 1 | Address falls in main memory |
| hit_sec_i | input | 1 | Address falls in secondary bus range |
| mem_locked_i | input | 1 | Main memory locked by processor or secondary agent |
| posted_wr_pend_i | input | 1 | Processor posted/deferred write data awaiting flush |
| pipe_req_pend_i | input | 1 | Pipelined or sideband request pending |
| data_ready_i | input | 1 | Memory side ready for the current data phase |
| master_last_i | input | 1 | Current data phase is the master's last |
| claim_o | output | 1 | Access claimed and in progress |
| to_mem_o | output | 1 | Claimed access routed to main memory |
| to_sec_o | output | 1 | Claimed write routed to secondary bus |
| retry_o | output | 1 | Retry pulse on the first data phase |
| disconnect_o | output | 1 | Disconnect pulse on a later data phase |
| xfer_o | output | 1 | Data phase completed |
| dt_capture_o | output | 1 | Retried read stored as delayed transaction |
| dt_hit_o | output | 1 | Repeat of the stored read completed |

## Verification
The two first-phase functions that can land on the same edge are the 32-clock retry and the completion of the transfer. To provoke this, a write is held in wait states with a pipelined request pending for 31 edges, and the data is then offered exactly on the 32nd. The outcome is judged correct only if `xfer_o` pulses while `retry_o` stays low. A second overlap checked is a retry that also captures a delayed read: `dt_capture_o` must come in the same clock as `retry_o`. The bench confirms that the capture is withheld when the slot is already full.

// File: rtl/brg_pkg.sv
package brg_pkg;

    localparam logic [3:0] CMD_MEM_RD     = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR     = 4'b0111;
    localparam logic [3:0] CMD_CFG_RD     = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR     = 4'b1011;
    localparam logic [3:0] CMD_MEM_RD_MUL = 4'b1100;
    localparam logic [3:0] CMD_MEM_RD_LN  = 4'b1110;
    localparam logic [3:0] CMD_MEM_WR_INV = 4'b1111;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_LATER = 2'd2
    } tgt_state_e;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_MEM  = 2'd1,
        RT_SEC  = 2'd2
    } route_e;

endpackage

// File: rtl/brg_cmd_decode.sv
module brg_cmd_decode
    import brg_pkg::*;
(
    input  logic [3:0] cmd_i,
    input  logic       hit_mem_i,
    input  logic       hit_sec_i,
    output logic       claim_o,
    output logic       is_read_o,
    output route_e     route_o
);

    logic rd_cmd;
    logic wr_cmd;

    always_comb begin
        rd_cmd = 1'b0;
        wr_cmd = 1'b0;
        case (cmd_i)
            CMD_MEM_RD, CMD_MEM_RD_LN, CMD_MEM_RD_MUL: rd_cmd = 1'b1;
            CMD_MEM_WR, CMD_MEM_WR_INV:                wr_cmd = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        claim_o   = 1'b0;
        route_o   = RT_NONE;
        is_read_o = rd_cmd;
        if (rd_cmd && hit_mem_i) begin
            claim_o = 1'b1;
            route_o = RT_MEM;
        end else if (wr_cmd && hit_mem_i) begin
            claim_o = 1'b1;
            route_o = RT_MEM;
        end else if (wr_cmd && hit_sec_i) begin
            claim_o = 1'b1;
            route_o = RT_SEC;
        end
    end

    always_comb begin
        if (route_o == RT_SEC)
            assert (!rd_cmd) else $error("AST_READ_TO_SECONDARY"); // R1
    end

endmodule

// File: rtl/brg_phase_timer.sv
module brg_phase_timer #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic term_o
);

    localparam int          CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign term_o = (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i && !term_o)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TIMER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0)) else $error("AST_TIMER_CLEARS"); // R9

    AST_TIMER_HOLDS_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (term_o && !clr_i) |=> term_o) else $error("AST_TIMER_HOLDS_AT_TERM"); // R5

endmodule

// File: rtl/brg_dt_slot.sv
module brg_dt_slot #(
    parameter int ADDR_W = 32,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              rel_i,
    input  logic [3:0]        cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BE_W-1:0]   be_i,
    output logic              valid_o,
    output logic              match_o
);

    typedef struct packed {
        logic              valid;
        logic [3:0]        cmd;
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
    } slot_t;

    slot_t slot_d, slot_q;

    assign valid_o = slot_q.valid;
    assign match_o = slot_q.valid && (slot_q.cmd == cmd_i)
                  && (slot_q.addr == addr_i) && (slot_q.be == be_i);

    always_comb begin
        slot_d = slot_q;
        if (cap_i) begin
            slot_d.valid = 1'b1;
            slot_d.cmd   = cmd_i;
            slot_d.addr  = addr_i;
            slot_d.be    = be_i;
        end else if (rel_i) begin
            slot_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    AST_SLOT_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |-> !slot_q.valid) else $error("AST_SLOT_NO_OVERWRITE"); // R7

    AST_SLOT_RELEASE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rel_i |-> match_o) else $error("AST_SLOT_RELEASE_ON_MATCH"); // R8

endmodule

// File: rtl/brg_target_ctrl.sv
module brg_target_ctrl
    import brg_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BE_W        = 4,
    parameter int FIRST_LIMIT = 32,
    parameter int LATER_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic [3:0]        cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BE_W-1:0]   byte_en_i,
    input  logic              hit_mem_i,
    input  logic              hit_sec_i,
    input  logic              mem_locked_i,
    input  logic              posted_wr_pend_i,
    input  logic              pipe_req_pend_i,
    input  logic              data_ready_i,
    input  logic              master_last_i,
    output logic              claim_o,
    output logic              to_mem_o,
    output logic              to_sec_o,
    output logic              retry_o,
    output logic              disconnect_o,
    output logic              xfer_o,
    output logic              dt_capture_o,
    output logic              dt_hit_o
);

    typedef struct packed {
        tgt_state_e        state;
        logic [3:0]        cmd;
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
        logic              is_read;
        route_e            route;
        logic              claim;
        logic              retry;
        logic              disc;
        logic              xfer;
        logic              dt_cap;
        logic              dt_hit;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic   dec_claim;
    logic   dec_read;
    route_e dec_route;
    logic   first_clr, first_inc, first_term;
    logic   later_clr, later_inc, later_term;
    logic   slot_cap, slot_rel, slot_valid, slot_match;
    logic   retry_now, end_now, slot_block;

    brg_cmd_decode u_decode (
        .cmd_i     (cmd_i),
        .hit_mem_i (hit_mem_i),
        .hit_sec_i (hit_sec_i),
        .claim_o   (dec_claim),
        .is_read_o (dec_read),
        .route_o   (dec_route)
    );

    brg_phase_timer #(.LIMIT(FIRST_LIMIT)) u_first_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (first_clr),
        .inc_i  (first_inc),
        .term_o (first_term)
    );

    brg_phase_timer #(.LIMIT(LATER_LIMIT)) u_later_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (later_clr),
        .inc_i  (later_inc),
        .term_o (later_term)
    );

    brg_dt_slot #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dt_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (slot_cap),
        .rel_i   (slot_rel),
        .cmd_i   (ctl_q.cmd),
        .addr_i  (ctl_q.addr),
        .be_i    (ctl_q.be),
        .valid_o (slot_valid),
        .match_o (slot_match)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.retry  = 1'b0;
        ctl_d.disc   = 1'b0;
        ctl_d.xfer   = 1'b0;
        ctl_d.dt_cap = 1'b0;
        ctl_d.dt_hit = 1'b0;
        first_clr  = 1'b0;
        first_inc  = 1'b0;
        later_clr  = 1'b0;
        later_inc  = 1'b0;
        slot_cap   = 1'b0;
        slot_rel   = 1'b0;
        retry_now  = 1'b0;
        end_now    = 1'b0;
        slot_block = ctl_q.is_read && slot_valid && !slot_match;

        case (ctl_q.state)
            ST_IDLE: begin
                if (frame_start_i) begin
                    first_clr     = 1'b1;
                    ctl_d.cmd     = cmd_i;
                    ctl_d.addr    = addr_i;
                    ctl_d.be      = byte_en_i;
                    ctl_d.is_read = dec_read;
                    if (dec_claim) begin
                        ctl_d.state = ST_FIRST;
                        ctl_d.claim = 1'b1;
                        ctl_d.route = dec_route;
                    end
                end
            end
            ST_FIRST: begin
                if (mem_locked_i || (ctl_q.is_read && posted_wr_pend_i) || slot_block) begin
                    retry_now = 1'b1;
                end else if (data_ready_i) begin
                    ctl_d.xfer = 1'b1;
                    if (ctl_q.is_read && slot_match) begin
                        ctl_d.dt_hit = 1'b1;
                        slot_rel     = 1'b1;
                    end
                    if (master_last_i) begin
                        end_now = 1'b1;
                    end else begin
                        ctl_d.state = ST_LATER;
                        later_clr   = 1'b1;
                    end
                end else begin
                    first_inc = 1'b1;
                    if (first_term && pipe_req_pend_i)
                        retry_now = 1'b1;
                end
                if (retry_now) begin
                    ctl_d.retry = 1'b1;
                    end_now     = 1'b1;
                    if (ctl_q.is_read && !slot_valid) begin
                        slot_cap     = 1'b1;
                        ctl_d.dt_cap = 1'b1;
                    end
                end
            end
            ST_LATER: begin
                if (data_ready_i) begin
                    ctl_d.xfer = 1'b1;
                    later_clr  = 1'b1;
                    if (master_last_i)
                        end_now = 1'b1;
                end else begin
                    later_inc = 1'b1;
                    if (later_term) begin
                        ctl_d.disc = 1'b1;
                        end_now    = 1'b1;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase

        if (end_now) begin
            ctl_d.state = ST_IDLE;
            ctl_d.claim = 1'b0;
            ctl_d.route = RT_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
            ctl_q.route <= RT_NONE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign claim_o      = ctl_q.claim;
    assign to_mem_o     = (ctl_q.route == RT_MEM);
    assign to_sec_o     = (ctl_q.route == RT_SEC);
    assign retry_o      = ctl_q.retry;
    assign disconnect_o = ctl_q.disc;
    assign xfer_o       = ctl_q.xfer;
    assign dt_capture_o = ctl_q.dt_cap;
    assign dt_hit_o     = ctl_q.dt_hit;

    AST_CFG_NEVER_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_IDLE && frame_start_i && (cmd_i == CMD_CFG_RD || cmd_i == CMD_CFG_WR))
        |=> !claim_o) else $error("AST_CFG_NEVER_CLAIMED"); // R1

    AST_WRITE_MEM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_IDLE && frame_start_i && hit_mem_i
         && (cmd_i == CMD_MEM_WR || cmd_i == CMD_MEM_WR_INV))
        |=> (to_mem_o && !to_sec_o)) else $error("AST_WRITE_MEM_FIRST"); // R2

    AST_LOCK_FORCES_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_FIRST && mem_locked_i) |=> (retry_o && !claim_o))
        else $error("AST_LOCK_FORCES_RETRY"); // R3

    AST_POSTED_READ_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_FIRST && ctl_q.is_read && posted_wr_pend_i) |=> retry_o)
        else $error("AST_POSTED_READ_RETRY"); // R4

    AST_DISC_FROM_LATER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disconnect_o) |-> ($past(ctl_q.state) == ST_LATER && !retry_o))
        else $error("AST_DISC_FROM_LATER"); // R6

    AST_CAPTURE_WITH_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        dt_capture_o |-> retry_o) else $error("AST_CAPTURE_WITH_RETRY"); // R7

    AST_HIT_WITH_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        dt_hit_o |-> xfer_o) else $error("AST_HIT_WITH_XFER"); // R8

    AST_READY_BEATS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_FIRST && data_ready_i && !mem_locked_i
         && !(ctl_q.is_read && posted_wr_pend_i) && !slot_block) |=> (xfer_o && !retry_o))
        else $error("AST_READY_BEATS_TIMEOUT"); // R10

endmodule

// File: tb/brg_target_ctrl_bench.sv
`timescale 1ns/1ps
module brg_target_ctrl_bench;
    import brg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [3:0]  cmd = 4'h0;
    logic [31:0] addr = '0;
    logic [3:0]  byte_en = '0;
    logic        hit_mem = 1'b0, hit_sec = 1'b0;
    logic        mem_locked = 1'b0, posted_wr_pend = 1'b0, pipe_req_pend = 1'b0;
    logic        data_ready = 1'b0, master_last = 1'b0;
    logic        claim, to_mem, to_sec, retry, disconnect, xfer, dt_capture, dt_hit;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    brg_target_ctrl u_brg_target_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start), .cmd_i(cmd),
        .addr_i(addr), .byte_en_i(byte_en), .hit_mem_i(hit_mem), .hit_sec_i(hit_sec),
        .mem_locked_i(mem_locked), .posted_wr_pend_i(posted_wr_pend),
        .pipe_req_pend_i(pipe_req_pend), .data_ready_i(data_ready),
        .master_last_i(master_last), .claim_o(claim), .to_mem_o(to_mem),
        .to_sec_o(to_sec), .retry_o(retry), .disconnect_o(disconnect),
        .xfer_o(xfer), .dt_capture_o(dt_capture), .dt_hit_o(dt_hit)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic start(input logic [3:0] c, input logic [31:0] a, input logic [3:0] be,
                         input logic hm, input logic hs);
        frame_start = 1'b1; cmd = c; addr = a; byte_en = be; hit_mem = hm; hit_sec = hs;
        tick();
        frame_start = 1'b0;
    endtask

    task automatic serve_last();
        data_ready = 1'b1; master_last = 1'b1;
        tick();
        data_ready = 1'b0; master_last = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11", "outputs after reset",
            {claim, to_mem, to_sec, retry, disconnect, xfer, dt_capture, dt_hit}, 8'h00);
    endtask

    task automatic t_decode();
        start(CMD_CFG_RD, 32'h100, 4'hF, 1'b1, 1'b0);
        chk("R1", "cfg read claim", claim, 1'b0);
        start(CMD_CFG_WR, 32'h104, 4'hF, 1'b1, 1'b1);
        chk("R1", "cfg write claim", claim, 1'b0);
        start(CMD_MEM_RD_MUL, 32'h200, 4'hF, 1'b0, 1'b1);
        chk("R1", "read to secondary claim", claim, 1'b0);
        start(4'b0011, 32'h200, 4'hF, 1'b1, 1'b1);
        chk("R1", "other command claim", claim, 1'b0);
        start(CMD_MEM_RD, 32'h300, 4'hF, 1'b1, 1'b0);
        chk("R1", "memory read claim/route", {claim, to_mem, to_sec}, 3'b110);
        serve_last();
        chk("R1", "read served xfer/claim", {xfer, claim, dt_hit}, 3'b100);
        start(CMD_MEM_WR, 32'h400, 4'h3, 1'b0, 1'b1);
        chk("R9", "back-to-back claim after completion", claim, 1'b1);
        chk("R2", "secondary write route", {to_mem, to_sec}, 2'b01);
        serve_last();
        start(CMD_MEM_WR_INV, 32'h500, 4'hF, 1'b1, 1'b1);
        chk("R2", "both ranges prefer memory", {claim, to_mem, to_sec}, 3'b110);
        serve_last();
        chk("R2", "write served", {xfer, claim}, 2'b10);
    endtask

    task automatic t_lock();
        mem_locked = 1'b1;
        start(CMD_MEM_WR, 32'h600, 4'hF, 1'b1, 1'b0);
        data_ready = 1'b1;
        tick();
        data_ready = 1'b0; mem_locked = 1'b0;
        chk("R3", "locked write retry/claim/xfer", {retry, claim, xfer, dt_capture}, 4'b1000);
    endtask

    task automatic t_posted();
        posted_wr_pend = 1'b1;
        start(CMD_MEM_WR, 32'h700, 4'hF, 1'b1, 1'b0);
        serve_last();
        chk("R4", "write ignores posted pending", {xfer, retry}, 2'b10);
        start(CMD_MEM_RD, 32'hA0, 4'h5, 1'b1, 1'b0);
        data_ready = 1'b1;
        tick();
        data_ready = 1'b0; posted_wr_pend = 1'b0;
        chk("R4", "read retried on posted pending", {retry, xfer}, 2'b10);
        chk("R7", "retried read captured", dt_capture, 1'b1);
    endtask

    task automatic t_delayed();
        start(CMD_MEM_RD_LN, 32'hA0, 4'h5, 1'b1, 1'b0);
        serve_last();
        chk("R8", "other command rejected", {retry, dt_capture, xfer}, 3'b100);
        start(CMD_MEM_RD, 32'hA4, 4'h5, 1'b1, 1'b0);
        serve_last();
        chk("R8", "other address rejected", {retry, dt_capture, xfer}, 3'b100);
        start(CMD_MEM_RD, 32'hA0, 4'h6, 1'b1, 1'b0);
        serve_last();
        chk("R8", "other byte enables rejected", {retry, dt_capture, xfer}, 3'b100);
        start(CMD_MEM_RD, 32'hA0, 4'h5, 1'b1, 1'b0);
        serve_last();
        chk("R8", "matching repeat completes", {xfer, dt_hit, retry}, 3'b110);
        start(CMD_MEM_RD_LN, 32'hB0, 4'hF, 1'b1, 1'b0);
        serve_last();
        chk("R8", "slot freed after hit", {xfer, dt_hit, retry}, 3'b100);
    endtask

    task automatic t_wait32();
        int bad = 0;
        start(CMD_MEM_WR, 32'hC0, 4'hF, 1'b1, 1'b0);
        for (int i = 0; i < 40; i++) begin
            tick();
            if (retry || !claim) bad++;
        end
        chk("R5", "long wait without pipe pending", bad, 0);
        pipe_req_pend = 1'b1;
        tick();
        chk("R5", "retry once pipe pending", {retry, claim, dt_capture}, 3'b100);
        start(CMD_MEM_WR, 32'hC4, 4'hF, 1'b1, 1'b0);
        bad = 0;
        for (int i = 0; i < 31; i++) begin
            tick();
            if (retry || !claim) bad++;
        end
        chk("R9", "count restarts on back-to-back", bad, 0);
        tick();
        chk("R5", "retry at 32nd wait clock", {retry, claim}, 2'b10);
    endtask

    task automatic t_tie();
        int bad = 0;
        start(CMD_MEM_WR, 32'hD0, 4'hF, 1'b1, 1'b0);
        for (int i = 0; i < 31; i++) begin
            tick();
            if (retry) bad++;
        end
        chk("R10", "no early retry", bad, 0);
        serve_last();
        pipe_req_pend = 1'b0;
        chk("R10", "ready wins over timeout", {xfer, retry}, 2'b10);
    endtask

    task automatic t_burst();
        int bad = 0;
        start(CMD_MEM_WR, 32'hE0, 4'hF, 1'b1, 1'b0);
        data_ready = 1'b1;
        tick();
        data_ready = 1'b0;
        chk("R6", "first transfer keeps claim", {xfer, claim}, 2'b11);
        for (int i = 0; i < 7; i++) begin
            tick();
            if (disconnect || !claim) bad++;
        end
        chk("R6", "seven unready clocks tolerated", bad, 0);
        data_ready = 1'b1;
        tick();
        data_ready = 1'b0;
        chk("R6", "late transfer accepted", {xfer, disconnect}, 2'b10);
        bad = 0;
        for (int i = 0; i < 7; i++) begin
            tick();
            if (disconnect) bad++;
        end
        chk("R6", "count restarted by transfer", bad, 0);
        tick();
        chk("R6", "disconnect on eighth unready", {disconnect, claim, retry}, 3'b100);
        start(CMD_MEM_WR, 32'hE4, 4'hF, 1'b0, 1'b1);
        chk("R9", "claim right after disconnect", {claim, to_sec}, 2'b11);
        serve_last();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_decode();
        t_lock();
        t_posted();
        t_delayed();
        t_wait32();
        t_tie();
        t_burst();
        repeat (2) tick();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule